// File: doc/BRIEF.md
# Non-Volatile SRAM Store/Recall Controller

This block models a byte-wide static RAM that has a second, non-volatile array of the same size behind it. Four active-low control pins (chip select, write strobe, output enable and a non-volatile strobe) are decoded into one operating mode on each rising clock edge. The decoded mode either accesses the SRAM one word at a time or starts a bulk copy between the two arrays. A save copies the SRAM into the shadow. A restore copies the shadow back into the SRAM.

Both bulk copies move one word per clock across every address. A save first waits `PROG_WAIT` cycles, which stands in for the long programming time of the shadow cells, and only then moves the data. While a copy runs, `busy` is high and all pin commands are ignored. Each time the power-good input rises, and when reset is released with power-good already high, the block runs a restore before it serves any access. A loss of power-good aborts any copy in progress. The array depth is `2**ADDR_W`. The default is kept small for elaboration, and `ADDR_W = 13` gives the full 8K x 8 organisation.

Top module: `nvsram_ctl`

## Requirements
- R1: While `cs_n` is high the block is in standby: `dout_en` is 0 on the next cycle and no SRAM word changes, whatever the other pins carry.
- R2: With `cs_n`=0, `wr_n`=1, `oe_n`=0 and `nv_n`=1 sampled at an edge, the SRAM word at `addr` appears on `dout` with `dout_en`=1 one cycle after that edge.
- R3: With `cs_n`=0, `wr_n`=0 and `nv_n`=1, `din` is written to the SRAM at `addr` whatever `oe_n` is, and `dout_en` stays 0.
- R4: Entering the save mode (`cs_n`=0, `wr_n`=0, `oe_n`=1, `nv_n`=0) makes `busy` high for exactly `PROG_WAIT + 2**ADDR_W` cycles. Afterwards the shadow array holds the SRAM image.
- R5: Entering the restore mode (`cs_n`=0, `wr_n`=1, `oe_n`=0, `nv_n`=0) makes `busy` high for exactly `2**ADDR_W` cycles. Afterwards every SRAM word equals the shadow word.
- R6: The no-op combinations (`wr_n`=0 with `oe_n`=0 and `nv_n`=0; `wr_n`=1 with `oe_n`=1) keep `dout_en` at 0, write nothing and start nothing.
- R7: A rise of `pwr_good`, or reset release with `pwr_good` high, starts a restore: `busy` is high on the next cycle and stays high for `2**ADDR_W` cycles. While `pwr_good` is low, no copy starts and no access is served.
- R8: `pwr_good` low at an edge aborts a running copy, so `busy` is 0 on the next cycle. A save aborted during its programming wait leaves the shadow array unchanged.
- R9: Raising `cs_n` during a copy does not shorten it.
- R10: While `busy` is high, reads, writes and copy commands on the pins are ignored.
- R11: A copy starts only when its mode is entered. Holding the mode across later edges does not start it again.
- R12: The synchronous active-low reset clears the controller state and leaves the contents of both arrays intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pins are sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the controller state |
| pwr_good | input | 1 | Supply-good indication |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| nv_n | input | 1 | Non-volatile strobe, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero while not enabled |
| dout_en | output | 1 | Drive enable for `dout` (low means high impedance) |
| busy | output | 1 | High while a save or restore runs |

## Verification
A read result is due one cycle after the edge that samples the read mode. `busy` rises one cycle after the edge that sees a copy mode entered or power-good rise. After that, `busy` stays high for `2**ADDR_W` cycles for a restore and `PROG_WAIT + 2**ADDR_W` cycles for a save. The bench drives the pins on the falling edge and samples on the next falling edge, so each rising edge between the two sees stable inputs. It counts `busy` cycles one falling edge at a time and compares the count with those sums. Power loss is checked on the falling edge right after `pwr_good` goes low, where `busy` must already be 0.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [2:0] {
    M_STANDBY,
    M_READ,
    M_WRITE,
    M_RECALL,
    M_STORE,
    M_NOP
  } mode_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_PROG,
    S_STORE,
    S_RECALL
  } seq_state_e;

  // Pin decode; all pins active low.
  function automatic mode_e decode_pins(input logic cs_n, input logic wr_n,
                                        input logic oe_n, input logic nv_n);
    mode_e m;
    if (cs_n) begin
      m = M_STANDBY;
    end else if (nv_n) begin
      if (!wr_n)      m = M_WRITE;
      else if (!oe_n) m = M_READ;
      else            m = M_NOP;
    end else begin
      if (wr_n) m = oe_n ? M_NOP : M_RECALL;
      else      m = oe_n ? M_STORE : M_NOP;
    end
    return m;
  endfunction

  // Busy length of a save: programming wait, then one word per cycle.
  function automatic int unsigned save_cycles(input int unsigned prog_wait,
                                              input int unsigned depth);
    return prog_wait + depth;
  endfunction

  // Busy length of a restore: one word per cycle.
  function automatic int unsigned restore_cycles(input int unsigned depth);
    return depth;
  endfunction

endpackage

// File: rtl/nvs_mode_decode.sv
module nvs_mode_decode
  import nvs_pkg::*;
(
  input  logic  cs_n,
  input  logic  wr_n,
  input  logic  oe_n,
  input  logic  nv_n,
  output mode_e mode
);
  always_comb mode = decode_pins(cs_n, wr_n, oe_n, nv_n);
endmodule

// File: rtl/nvs_mem.sv
module nvs_mem #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  // No reset: contents survive a controller reset.
  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
  import nvs_pkg::*;
#(
  parameter int AW        = 10,
  parameter int PROG_WAIT = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_good,
  input  mode_e         mode,
  output logic          busy,
  output logic [AW-1:0] xfer_idx,
  output logic          store_wr,
  output logic          recall_wr,
  output logic          start_store,
  output logic          start_recall,
  output logic          done
);
  localparam int DEPTH = 1 << AW;
  localparam int PW_W  = $clog2(PROG_WAIT + 1);
  localparam int CW    = (AW > PW_W) ? AW : PW_W;

  seq_state_e    state;
  logic [CW-1:0] cnt;
  mode_e         prev_mode;
  logic          pg_q;

  logic pwr_rise, enter_store, enter_recall, xfer_last, prog_last, in_xfer;

  assign pwr_rise     = pwr_good && !pg_q;
  assign enter_store  = (mode == M_STORE)  && (prev_mode != M_STORE);
  assign enter_recall = (mode == M_RECALL) && (prev_mode != M_RECALL);
  assign xfer_last    = (cnt == CW'(DEPTH - 1));
  assign prog_last    = (cnt == CW'(PROG_WAIT - 1));
  assign in_xfer      = (state == S_STORE) || (state == S_RECALL);

  assign busy         = (state != S_IDLE);
  assign xfer_idx     = cnt[AW-1:0];
  assign start_recall = pwr_good && (state == S_IDLE) && (pwr_rise || enter_recall);
  assign start_store  = pwr_good && (state == S_IDLE) && !start_recall && enter_store;
  assign store_wr     = pwr_good && (state == S_STORE);
  assign recall_wr    = pwr_good && (state == S_RECALL);
  assign done         = pwr_good && in_xfer && xfer_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      prev_mode <= M_STANDBY;
      pg_q      <= 1'b0;
    end else begin
      pg_q      <= pwr_good;
      prev_mode <= mode;
      if (!pwr_good) begin
        state <= S_IDLE;
        cnt   <= '0;
      end else begin
        unique case (state)
          S_IDLE: begin
            cnt <= '0;
            if (start_recall)     state <= S_RECALL;
            else if (start_store) state <= S_PROG;
          end
          S_PROG: begin
            if (prog_last) begin
              state <= S_STORE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STORE, S_RECALL: begin
            if (xfer_last) begin
              state <= S_IDLE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R8
  pwr_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> !busy);

  // R4
  store_after_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STORE && $past(state) != S_STORE) |-> ($past(state) == S_PROG));

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: rtl/nvsram_ctl.sv
module nvsram_ctl
  import nvs_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int PROG_WAIT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              oe_n,
  input  logic              nv_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy
);
  mode_e             mode;
  logic [ADDR_W-1:0] xfer_idx;
  logic              store_wr, recall_wr, start_store, start_recall, done;
  logic              host_wr, host_rd;
  logic              sram_we;
  logic [ADDR_W-1:0] sram_waddr, sram_raddr;
  logic [DATA_W-1:0] sram_wdata, sram_rdata, nv_rdata;
  logic [DATA_W-1:0] dout_q;

  nvs_mode_decode u_dec (
    .cs_n (cs_n),
    .wr_n (wr_n),
    .oe_n (oe_n),
    .nv_n (nv_n),
    .mode (mode)
  );

  nvs_seq #(.AW(ADDR_W), .PROG_WAIT(PROG_WAIT)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_good     (pwr_good),
    .mode         (mode),
    .busy         (busy),
    .xfer_idx     (xfer_idx),
    .store_wr     (store_wr),
    .recall_wr    (recall_wr),
    .start_store  (start_store),
    .start_recall (start_recall),
    .done         (done)
  );

  assign host_wr    = (mode == M_WRITE) && !busy && pwr_good;
  assign host_rd    = (mode == M_READ)  && !busy && pwr_good;
  assign sram_we    = host_wr || recall_wr;
  assign sram_waddr = host_wr ? addr : xfer_idx;
  assign sram_wdata = host_wr ? din  : nv_rdata;
  assign sram_raddr = busy ? xfer_idx : addr;

  nvs_mem #(.AW(ADDR_W), .DW(DATA_W)) u_sram (
    .clk   (clk),
    .we    (sram_we),
    .waddr (sram_waddr),
    .wdata (sram_wdata),
    .raddr (sram_raddr),
    .rdata (sram_rdata)
  );

  nvs_mem #(.AW(ADDR_W), .DW(DATA_W)) u_shadow (
    .clk   (clk),
    .we    (store_wr),
    .waddr (xfer_idx),
    .wdata (sram_rdata),
    .raddr (xfer_idx),
    .rdata (nv_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_en <= 1'b0;
      dout_q  <= '0;
    end else begin
      dout_en <= host_rd;
      if (host_rd) dout_q <= sram_rdata;
    end
  end

  assign dout = dout_en ? dout_q : '0;

  // R10
  busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !dout_en);

  // R3
  write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_WRITE) |=> !dout_en);

  // R1
  standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_STANDBY) |=> !dout_en);

  // R7
  pwr_rise_recall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_good) |=> busy);

  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_store || start_recall) |=> busy);

  // R10
  exclusive_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && (recall_wr || store_wr)));

endmodule

// File: tb/test_nvsram_ctl.sv
module test_nvsram_ctl;
  import nvs_pkg::*;

  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int PW    = 5;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n, pwr_good, cs_n, wr_n, oe_n, nv_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic dout_en, busy;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  nvsram_ctl #(.ADDR_W(AW), .DATA_W(DW), .PROG_WAIT(PW)) i_nvsram_ctl (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .cs_n(cs_n), .wr_n(wr_n),
    .oe_n(oe_n), .nv_n(nv_n), .addr(addr), .din(din), .dout(dout),
    .dout_en(dout_en), .busy(busy)
  );

  function automatic logic [DW-1:0] pat_f(input int a); return DW'(a * 7 + 3); endfunction
  function automatic logic [DW-1:0] pat_g(input int a); return DW'(a ^ 8'hA5); endfunction
  function automatic logic [DW-1:0] pat_h(input int a); return DW'(~a); endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pins(input logic c, input logic w, input logic o, input logic n);
    cs_n = c; wr_n = w; oe_n = o; nv_n = n;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_write(input int a, input logic [DW-1:0] d, input logic o, input string req);
    pins(1'b0, 1'b0, o, 1'b1); addr = AW'(a); din = d;
    @(negedge clk);
    chk(req, int'(dout_en), 0);
    pins(1'b1, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic do_read(input int a, output logic [DW-1:0] d, output logic en);
    pins(1'b0, 1'b1, 1'b0, 1'b1); addr = AW'(a);
    @(negedge clk);
    d = dout; en = dout_en;
    pins(1'b1, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic read_all(input int sel, input string req);
    logic [DW-1:0] d, e;
    logic en;
    for (int a = 0; a < DEPTH; a++) begin
      do_read(a, d, en);
      e = (sel == 0) ? pat_f(a) : (sel == 1) ? pat_g(a) : pat_h(a);
      chk({req, " read enable"}, int'(en), 1);
      chk({req, " read data"}, int'(d), int'(e));
    end
  endtask

  task automatic write_all(input int sel);
    for (int a = 0; a < DEPTH; a++)
      do_write(a, (sel == 0) ? pat_f(a) : (sel == 1) ? pat_g(a) : pat_h(a),
               logic'(a[0]), "R3 write hiz");
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;
    logic [DW-1:0] d;
    logic en;
    rst_n = 1'b0; pwr_good = 1'b0; pins(1'b1, 1'b1, 1'b1, 1'b1);
    addr = '0; din = '0;
    repeat (3) @(negedge clk);
    chk("R12 reset busy", int'(busy), 0);
    chk("R12 reset dout_en", int'(dout_en), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 no copy without power", int'(busy), 0);

    // R7 power-up restore
    pwr_good = 1'b1;
    @(negedge clk);
    chk("R7 busy after power rise", int'(busy), 1);
    wait_idle(n);
    chk("R7 restore length", n, int'(restore_cycles(DEPTH)));

    // R2, R3 sweep
    write_all(0);
    read_all(0, "R2");

    // R4 save, with cs_n raised during it (R9)
    pins(1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    chk("R4 busy after save entry", int'(busy), 1);
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    wait_idle(n);
    chk("R9 R4 save length", n, int'(save_cycles(PW, DEPTH)));

    // R5 restore brings back the saved image
    write_all(1);
    pins(1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk("R5 busy after restore entry", int'(busy), 1);
    // R11: keep the mode held through and after the copy
    wait_idle(n);
    chk("R5 restore length", n, int'(restore_cycles(DEPTH)));
    repeat (4) begin
      @(negedge clk);
      chk("R11 no retrigger while held", int'(busy), 0);
    end
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    read_all(0, "R5");

    // R10 commands ignored while busy
    pins(1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk("R10 busy", int'(busy), 1);
    pins(1'b0, 1'b0, 1'b1, 1'b1); addr = '0; din = 8'h5A;
    @(negedge clk);
    pins(1'b0, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    chk("R10 read ignored while busy", int'(dout_en), 0);
    pins(1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    wait_idle(n);
    chk("R10 no extra copy", 3 + n, int'(restore_cycles(DEPTH)));
    do_read(0, d, en);
    chk("R10 write ignored while busy", int'(d), int'(pat_f(0)));

    // R6 no-op combinations, R1 standby
    din = 8'hEE; addr = AW'(3);
    pins(1'b0, 1'b0, 1'b0, 1'b0); @(negedge clk);
    chk("R6 nop a hiz", int'(dout_en), 0);
    chk("R6 nop a no start", int'(busy), 0);
    pins(1'b0, 1'b1, 1'b1, 1'b1); @(negedge clk);
    chk("R6 nop b hiz", int'(dout_en), 0);
    pins(1'b0, 1'b1, 1'b1, 1'b0); @(negedge clk);
    chk("R6 nop c hiz", int'(dout_en), 0);
    chk("R6 nop c no start", int'(busy), 0);
    pins(1'b1, 1'b0, 1'b0, 1'b1); @(negedge clk);
    chk("R1 standby hiz", int'(dout_en), 0);
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    do_read(3, d, en);
    chk("R1 R6 no write", int'(d), int'(pat_f(3)));

    // R12 reset keeps arrays: shadow = g, SRAM = h, reset -> restore -> g
    write_all(1);
    pins(1'b0, 1'b0, 1'b1, 1'b0); @(negedge clk);
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    wait_idle(n);
    write_all(2);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R12 R7 restore after reset", int'(busy), 1);
    wait_idle(n);
    chk("R12 restore length", n, int'(restore_cycles(DEPTH)));
    read_all(1, "R12");

    // R8 power loss during programming wait
    write_all(2);
    pins(1'b0, 1'b0, 1'b1, 1'b0); @(negedge clk);
    chk("R8 save started", int'(busy), 1);
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    pwr_good = 1'b0;
    @(negedge clk);
    chk("R8 abort", int'(busy), 0);
    do_read(2, d, en);
    chk("R7 no read without power", int'(en), 0);
    pwr_good = 1'b1;
    @(negedge clk);
    chk("R7 restore after return", int'(busy), 1);
    wait_idle(n);
    read_all(1, "R8");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule